// File: doc/BRIEF.md
# 256-Byte Hamming ECC Generator

This block watches a byte stream as it moves between memory and a NAND flash device, in either direction. For every run of 256 accepted bytes it builds a single-error-correcting parity code. The code has two parts. Line parity records which byte address a flipped bit sits at. Column parity records which bit position inside the byte it sits at. When a chunk ends, the raw parity word is held in a readable result register. The word is also packed into three spare-area bytes. When streaming is selected, those three bytes are sent out on an output byte stream.

The input stream uses valid/ready. A byte is taken on a clock edge where `s_valid` and `s_ready` are both high. `s_ready` is low in three cases: accumulation is disabled, a clear pulse is present, or the chunk is one byte short of complete while code bytes from the previous chunk are still undelivered. The last case is the block's only back-pressure. It ensures a finished code is never overwritten before it leaves. The output stream follows the usual rule: `m_valid` and `m_data` hold steady until `m_ready` is seen high on a clock edge. Correcting errors, the transfer chain and the placement of the code in the spare area are all handled outside this block.

Top module: `hamming_chunk_ecc`

## Requirements
- R1: A byte is taken on a clock edge exactly when `s_valid` and `s_ready` are both high. `s_ready` equals `cfg_en` and not `ctl_clr` and not (the chunk holds 255 bytes and code bytes are still pending).
- R2: For each taken byte, let its chunk address be a (0..255) and its parity be p (XOR of its 8 bits). For every address bit k, p is XORed into raw bit 6+2k+a[k]. So bit 6+2k collects bytes whose address bit k is 0, and bit 7+2k collects bytes whose address bit k is 1.
- R3: For every bit b of a taken byte and every index bit j (0..2) of b, the data bit is XORed into raw bit 2j+b[j]. This fills raw bits 5:0.
- R4: On the edge that takes the 256th byte of a chunk, the finished 22-bit word is loaded into `ecc_raw` and the accumulator and byte count restart from zero. `chunk_done` is high for exactly the one following cycle. `ecc_raw` changes at no other time.
- R5: `ecc_code` equals the bitwise inverse of `ecc_raw` shifted left by two, kept to 24 bits. Its two low bits are therefore always 1.
- R6: If `cfg_stream` is high when a chunk ends, the three code bytes are sent on `m_data` in this order: bits 23:16, then 15:8, then 7:0. Each byte is held with `m_valid` until it is taken with `m_ready`.
- R7: A `ctl_clr` pulse zeroes the accumulator and the byte count and drops any pending code bytes. No byte is taken in that cycle.
- R8: While `cfg_en` is low, `s_ready` is low. The byte count and the accumulator keep their values, so bytes offered then have no effect on any later code.
- R9: When the 256th byte is offered while code bytes are still pending, `s_ready` stays low until the last pending code byte has been taken.
- R10: If `cfg_stream` is low when a chunk ends, `m_valid` stays low. The result still appears in `ecc_raw`.
- R11: After reset, `ecc_raw` is 0, `ecc_code` is 24'hFFFFFF, and `m_valid` and `chunk_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | 1 | Accumulation enable |
| cfg_stream | input | 1 | Send the packed code on the output stream at each chunk end |
| ctl_clr | input | 1 | One-cycle clear of the accumulator and count |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Input byte accepted |
| s_data | input | 8 | Input byte |
| m_valid | output | 1 | Code byte valid |
| m_ready | input | 1 | Code byte taken |
| m_data | output | 8 | Code byte, most significant first |
| chunk_done | output | 1 | One-cycle pulse after a chunk completes |
| ecc_raw | output | 22 | Latched raw parity word |
| ecc_code | output | 24 | Packed code of the latched word |

## Verification
The inner state of this block shows at the ports only at chunk boundaries. A wrong parity bit, a miscounted address or a lost clear therefore stays hidden until `ecc_raw` updates. That happens up to 256 accepted bytes later, and `ecc_code` and the streamed bytes are wrong from that same cycle. A wrong byte count shows sooner, as a `chunk_done` pulse on the wrong cycle or as `s_ready` falling at the wrong place. The bench compares every output on every cycle with a behavioural model, using patterns that each touch one line or column bit, so that a bad bit points to its cause.

// File: rtl/hce_pkg.sv
package hce_pkg;
  localparam int BYTE_W     = 8;
  localparam int IDX_W      = $clog2(BYTE_W);
  localparam int ADDR_W     = 8;
  localparam int LINE_W     = 2 * ADDR_W;
  localparam int COL_W      = 2 * IDX_W;
  localparam int RAW_W      = LINE_W + COL_W;
  localparam int PAD_W      = 2;
  localparam int CODE_W     = ((RAW_W + PAD_W + BYTE_W - 1) / BYTE_W) * BYTE_W;
  localparam int CODE_BYTES = CODE_W / BYTE_W;

  typedef logic [RAW_W-1:0]  raw_t;
  typedef logic [CODE_W-1:0] code_t;

  // Shift the raw word up by the pad, widen to whole bytes, invert.
  function automatic code_t pack_code(input raw_t r);
    code_t w;
    w = code_t'({r, {PAD_W{1'b0}}});
    return ~w;
  endfunction
endpackage

// File: rtl/hce_accum.sv
module hce_accum
  import hce_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              take,
  input  logic [BYTE_W-1:0] data,
  output logic              last,
  output logic              chunk_end,
  output logic              done_o,
  output raw_t              raw_o
);
  logic [ADDR_W-1:0] cnt_q;
  logic [LINE_W-1:0] line_q, line_nx;
  logic [COL_W-1:0]  col_q, col_nx;
  logic              par;

  assign par       = ^data;
  assign last      = &cnt_q;
  assign chunk_end = take & last;

  // Line parity: each address bit splits bytes into a true and a complement half.
  for (genvar k = 0; k < ADDR_W; k++) begin : g_line
    assign line_nx[2*k]   = line_q[2*k]   ^ (par & ~cnt_q[k]);
    assign line_nx[2*k+1] = line_q[2*k+1] ^ (par &  cnt_q[k]);
  end

  // Column parity: each bit-index bit splits the byte lanes into two halves.
  always_comb begin
    col_nx = col_q;
    for (int b = 0; b < BYTE_W; b++) begin
      for (int j = 0; j < IDX_W; j++) begin
        if (((b >> j) & 1) != 0) col_nx[2*j+1] = col_nx[2*j+1] ^ data[b];
        else                     col_nx[2*j]   = col_nx[2*j]   ^ data[b];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      line_q <= '0;
      col_q  <= '0;
      raw_o  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= chunk_end;
      if (clr) begin
        cnt_q  <= '0;
        line_q <= '0;
        col_q  <= '0;
      end else if (take) begin
        cnt_q <= cnt_q + ADDR_W'(1);
        if (last) begin
          raw_o  <= {line_nx, col_nx};
          line_q <= '0;
          col_q  <= '0;
        end else begin
          line_q <= line_nx;
          col_q  <= col_nx;
        end
      end
    end
  end

  AST_WRAP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_end |=> (done_o && cnt_q == '0 && line_q == '0 && col_q == '0)); // R4
  AST_RAW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !chunk_end |=> $stable(raw_o)); // R4
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0 && line_q == '0 && col_q == '0)); // R7
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !clr) |=> ($stable(cnt_q) && $stable(line_q) && $stable(col_q))); // R8
endmodule

// File: rtl/hce_emit.sv
module hce_emit
  import hce_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  raw_t              raw,
  input  logic              m_ready,
  output code_t             code,
  output logic              m_valid,
  output logic [BYTE_W-1:0] m_data,
  output logic              busy
);
  localparam int              SEL_W    = $clog2(CODE_BYTES);
  localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(CODE_BYTES - 1);

  logic [BYTE_W-1:0] code_b [CODE_BYTES];
  logic [SEL_W-1:0]  sel_q;
  logic              pend_q;

  assign code = pack_code(raw);

  // Lane 0 is the most significant byte of the packed code.
  for (genvar i = 0; i < CODE_BYTES; i++) begin : g_lane
    assign code_b[i] = code[CODE_W-1-i*BYTE_W -: BYTE_W];
  end

  always_comb begin
    m_data = '0;
    for (int i = 0; i < CODE_BYTES; i++)
      if (sel_q == SEL_W'(i)) m_data = code_b[i];
  end

  assign m_valid = pend_q;
  assign busy    = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      sel_q  <= '0;
    end else if (clr) begin
      pend_q <= 1'b0;
      sel_q  <= '0;
    end else if (load) begin
      pend_q <= 1'b1;
      sel_q  <= '0;
    end else if (pend_q && m_ready) begin
      if (sel_q == LAST_SEL) begin
        pend_q <= 1'b0;
        sel_q  <= '0;
      end else begin
        sel_q <= sel_q + SEL_W'(1);
      end
    end
  end

  AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready && !clr) |=> (m_valid && $stable(m_data))); // R6
  AST_NO_LOAD_OVER: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !pend_q); // R9
endmodule

// File: rtl/hamming_chunk_ecc.sv
module hamming_chunk_ecc
  import hce_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_stream,
  input  logic              ctl_clr,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [BYTE_W-1:0] s_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [BYTE_W-1:0] m_data,
  output logic              chunk_done,
  output logic [RAW_W-1:0]  ecc_raw,
  output logic [CODE_W-1:0] ecc_code
);
  logic take, last, chunk_end, busy;

  assign s_ready = cfg_en & ~ctl_clr & ~(last & busy);
  assign take    = s_valid & s_ready;

  hce_accum i_accum (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (ctl_clr),
    .take      (take),
    .data      (s_data),
    .last      (last),
    .chunk_end (chunk_end),
    .done_o    (chunk_done),
    .raw_o     (ecc_raw)
  );

  hce_emit i_emit (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (ctl_clr),
    .load    (chunk_end & cfg_stream),
    .raw     (ecc_raw),
    .m_ready (m_ready),
    .code    (ecc_code),
    .m_valid (m_valid),
    .m_data  (m_data),
    .busy    (busy)
  );

  AST_OFF_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |-> !s_ready); // R8
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (last && m_valid) |-> !s_ready); // R9
  AST_QUIET_NO_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_end && !cfg_stream) |=> !m_valid); // R10
  AST_CLR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_clr |-> !s_ready); // R7
endmodule

// File: tb/test_hamming_chunk_ecc.sv
module test_hamming_chunk_ecc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_en = 1'b0, cfg_stream = 1'b0, ctl_clr = 1'b0;
  logic        s_valid = 1'b0, m_ready = 1'b0;
  logic [7:0]  s_data = 8'h00;
  logic        s_ready, m_valid, chunk_done;
  logic [7:0]  m_data;
  logic [21:0] ecc_raw;
  logic [23:0] ecc_code;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  hamming_chunk_ecc i_hamming_chunk_ecc (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_stream(cfg_stream),
    .ctl_clr(ctl_clr), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .chunk_done(chunk_done), .ecc_raw(ecc_raw), .ecc_code(ecc_code)
  );

  // Behavioural reference model.
  logic [7:0] q[$];
  int m_raw = 0, m_pend = 0, m_idx = 0;
  bit m_done = 0;

  function automatic int calc();
    int r = 0;
    for (int i = 0; i < q.size(); i++)
      for (int b = 0; b < 8; b++)
        if (q[i][b]) begin
          for (int k = 0; k < 8; k++) r ^= 1 << (6 + 2*k + ((i >> k) & 1));
          for (int j = 0; j < 3; j++) r ^= 1 << (2*j + ((b >> j) & 1));
        end
    return r;
  endfunction

  function automatic int packed_of(input int r);
    return (~(r << 2)) & 32'h00FF_FFFF;
  endfunction

  function automatic bit exp_ready();
    return cfg_en && !ctl_clr && !(q.size() == 255 && m_pend > 0);
  endfunction

  always @(posedge clk) begin
    bit tk;
    if (!rst_n) begin
      q.delete(); m_raw = 0; m_pend = 0; m_idx = 0; m_done = 0;
    end else begin
      tk = s_valid && exp_ready();
      m_done = 0;
      if (ctl_clr) begin
        q.delete(); m_pend = 0; m_idx = 0;
      end else begin
        if (m_pend > 0 && m_ready) begin m_pend--; m_idx++; end
        if (tk) begin
          q.push_back(s_data);
          if (q.size() == 256) begin
            m_raw = calc(); q.delete(); m_done = 1;
            if (cfg_stream) begin m_pend = 3; m_idx = 0; end
          end
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-cycle comparison, one time unit after the falling edge.
  always begin
    @(negedge clk); #1;
    if (rst_n && !finished) begin
      chk("R1 s_ready", int'(s_ready), int'(exp_ready()));
      chk("R4 chunk_done", int'(chunk_done), int'(m_done));
      chk("R2 line parity", int'(ecc_raw[21:6]), (m_raw >> 6) & 16'hFFFF);
      chk("R3 column parity", int'(ecc_raw[5:0]), m_raw & 6'h3F);
      chk("R5 ecc_code", int'(ecc_code), packed_of(m_raw));
      chk("R6 m_valid", int'(m_valid), int'(m_pend > 0));
      if (m_pend > 0)
        chk("R6 m_data", int'(m_data), (packed_of(m_raw) >> (8 * (2 - m_idx))) & 8'hFF);
    end
  end

  task automatic send(input logic [7:0] d);
    s_valid = 1'b1; s_data = d;
    #2;
    while (!s_ready) begin @(negedge clk); #2; end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    s_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=hang expected=completion");
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    int seed = 7;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    // R11: state after reset
    chk("R11 ecc_raw", int'(ecc_raw), 0);
    chk("R11 ecc_code", int'(ecc_code), 32'hFF_FFFF);
    chk("R11 m_valid", int'(m_valid), 0);
    chk("R11 chunk_done", int'(chunk_done), 0);
    chk("R8 ready while disabled", int'(s_ready), 0);
    @(negedge clk);

    // Incrementing bytes, streamed out, consumer always ready.
    cfg_en = 1; cfg_stream = 1; m_ready = 1;
    for (int i = 0; i < 256; i++) send(8'(i));
    idle(6);

    // All zeros: raw 0, packed all ones (R5).
    for (int i = 0; i < 256; i++) send(8'h00);
    idle(2); #2;
    chk("R5 zero chunk code", int'(ecc_code), 32'hFF_FFFF);
    @(negedge clk);

    // One set bit, address 0x5A, bit 3.
    for (int i = 0; i < 256; i++) send(i == 8'h5A ? 8'h08 : 8'h00);
    idle(2); #2;
    chk("R2 single bit line", int'(ecc_raw[21:6]), 16'b0110_0110_1001_1001);
    chk("R3 single bit column", int'(ecc_raw[5:0]), 6'b011010);
    @(negedge clk);

    // Random bytes with gaps and an enable-off window (R8).
    for (int i = 0; i < 256; i++) begin
      if (i == 100) begin
        s_valid = 1'b1; s_data = 8'hA5; cfg_en = 0;
        repeat (3) begin #2; chk("R8 no accept when off", int'(s_ready), 0); @(negedge clk); end
        cfg_en = 1; idle(1);
      end
      send(8'($urandom(seed + i)));
      if ((i % 7) == 3) idle(1);
    end
    idle(6);
    chk("R8 frozen result", int'(ecc_raw), m_raw);

    // Stream disabled (R10).
    cfg_stream = 0;
    for (int i = 0; i < 256; i++) send(8'(i * 3 + 1));
    idle(2); #2;
    chk("R10 no code bytes", int'(m_valid), 0);
    chk("R10 raw still latched", int'(ecc_raw), m_raw);
    @(negedge clk);

    // Clear mid-chunk with a byte offered (R7).
    cfg_stream = 1;
    for (int i = 0; i < 100; i++) send(8'hFF);
    ctl_clr = 1; s_valid = 1; s_data = 8'h81;
    #2; chk("R7 no accept during clear", int'(s_ready), 0);
    @(negedge clk); ctl_clr = 0;
    for (int i = 0; i < 256; i++) send(8'(i ^ 8'h3C));
    idle(6);
    chk("R7 result after clear", int'(ecc_raw), m_raw);

    // Back-pressure (R9).
    m_ready = 0;
    for (int i = 0; i < 256; i++) send(8'(255 - i));
    for (int i = 0; i < 255; i++) send(8'(i + 17));
    s_valid = 1; s_data = 8'h44;
    repeat (3) begin #2; chk("R9 stall on pending code", int'(s_ready), 0); @(negedge clk); end
    m_ready = 1;
    send(8'h44);
    idle(8);
    chk("R9 second chunk result", int'(ecc_raw), m_raw);

    finished = 1;
    summary();
    $finish;
  end
endmodule